// File: doc/BRIEF.md
# Fault Lamp Controller

This block decides whether the gate of the on-chip lamp driver is enabled. It takes the fault flags from the analog supervisor: undervoltage, overvoltage and load dump. It also takes two rotor speed-band flags, one meaning the rotor is below the low threshold (stalled or slow) and one meaning it is above the high threshold. A lamp-gate override input lets the lamp be driven from outside the block. Every asynchronous flag is brought into the clock domain through a two-flop synchronizer. The lamp demand is then resolved with a fixed priority: load dump first, then the override, then the internal fault logic.

The ignition input may share its pin with the low side of the lamp. While the lamp is lit, the driver therefore has to let go now and then so that the ignition level can be read. On each polling tick that arrives while the lamp is demanded, the block blanks the lamp for a fixed number of clocks. It raises a one-cycle strobe in the last cycle of that blank, and the ignition sensing logic samples its input on that strobe.

Top module: `lamp_fault_ctrl`

## Requirements
- R1: While rstN is low, lampOn and senseWindow are both 0.
- R2: Overvoltage lights the lamp whatever the speed-band flags say.
- R3: Undervoltage lights the lamp only while speedHigh is 1. With speedHigh at 0 it has no effect on lampOn.
- R4: speedLow (rotor slow or stopped) lights the lamp.
- R5: With no fault flag, no override and no blank in progress, lampOn is 0.
- R6: extGate lights the lamp even when no internal fault is present.
- R7: loadDump forces lampOn to 0, overriding extGate and every fault flag.
- R8: A pollTick sampled at a rising edge while the lamp is demanded and no blank is running starts a blank. lampOn is 0 for the BLANK_CYCLES cycles that follow that edge.
- R9: senseWindow is 1 only in the last cycle of a blank, for exactly one cycle per blank.
- R10: A pollTick that arrives while the lamp is not demanded, or while a blank is already running, is ignored: it neither starts nor extends a blank.
- R11: A change on any flag input reaches lampOn after exactly two rising edges (two-flop synchronizer). pollTick is synchronous and is not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| underVolt | input | 1 | Asynchronous undervoltage flag |
| overVolt | input | 1 | Asynchronous overvoltage flag |
| loadDump | input | 1 | Asynchronous load-dump flag |
| speedLow | input | 1 | Rotor speed below low threshold |
| speedHigh | input | 1 | Rotor speed above high threshold |
| extGate | input | 1 | External lamp-gate override |
| pollTick | input | 1 | Synchronous ignition-polling tick, one cycle wide |
| lampOn | output | 1 | Lamp driver gate enable |
| senseWindow | output | 1 | Ignition sample strobe, last blank cycle |

## Verification
The bench builds the block with BLANK_CYCLES set to 5 instead of the default 4. Five is odd and differs from the synchronizer depth, so an off-by-one in the blank length or in the placement of the sense strobe cannot hide behind a coincidence of values. The short blank also leaves room to fire a second polling tick while a blank is still running and see that it is ignored. It also allows flags to be dropped mid-blank within a few dozen cycles.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  // Strobes from the blanking control to the datapath
  typedef struct packed {
    logic blankActive;
    logic senseStrobe;
  } ctlStrobe_t;

  localparam int FLAG_W     = 6;
  localparam int IDX_UNDER  = 0;
  localparam int IDX_OVER   = 1;
  localparam int IDX_DUMP   = 2;
  localparam int IDX_SLOW   = 3;
  localparam int IDX_FAST   = 4;
  localparam int IDX_EXT    = 5;
endpackage

// File: rtl/lfc_sync.sv
module lfc_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : gStage
      if (s == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= '0;
          else       stage[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/lfc_datapath.sv
module lfc_datapath
  import lfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] flagsRaw,
  input  ctlStrobe_t        ctl,
  output logic              lampDemand,
  output logic              lampOn,
  output logic              senseWindow
);
  logic [FLAG_W-1:0] flagsSync;
  logic              faultHit;

  lfc_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (flagsRaw),
    .syncOut (flagsSync)
  );

  // Internal fault qualification by speed band
  always_comb begin
    faultHit = flagsSync[IDX_OVER]
             | flagsSync[IDX_SLOW]
             | (flagsSync[IDX_UNDER] & flagsSync[IDX_FAST]);
  end

  // Priority: load dump, then override, then fault logic
  always_comb begin
    if (flagsSync[IDX_DUMP])     lampDemand = 1'b0;
    else if (flagsSync[IDX_EXT]) lampDemand = 1'b1;
    else                         lampDemand = faultHit;
  end

  assign lampOn      = lampDemand & ~ctl.blankActive;
  assign senseWindow = ctl.senseStrobe;
endmodule

// File: rtl/lfc_control.sv
module lfc_control
  import lfc_pkg::*;
#(
  parameter int BLANK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pollTick,
  input  logic       lampDemand,
  output ctlStrobe_t ctl
);
  localparam int CNT_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BLANK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] blankCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    blankCnt <= '0;
    else if (blankCnt != '0)      blankCnt <= blankCnt - CNT_LAST;
    else if (pollTick && lampDemand) blankCnt <= CNT_LOAD;
  end

  always_comb begin
    ctl.blankActive = (blankCnt != '0);
    ctl.senseStrobe = (blankCnt == CNT_LAST);
  end
endmodule

// File: rtl/lamp_fault_ctrl.sv
module lamp_fault_ctrl
  import lfc_pkg::*;
#(
  parameter int BLANK_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic underVolt,
  input  logic overVolt,
  input  logic loadDump,
  input  logic speedLow,
  input  logic speedHigh,
  input  logic extGate,
  input  logic pollTick,
  output logic lampOn,
  output logic senseWindow
);
  logic [FLAG_W-1:0] flagsRaw;
  logic              lampDemand;
  ctlStrobe_t        ctl;

  always_comb begin
    flagsRaw            = '0;
    flagsRaw[IDX_UNDER] = underVolt;
    flagsRaw[IDX_OVER]  = overVolt;
    flagsRaw[IDX_DUMP]  = loadDump;
    flagsRaw[IDX_SLOW]  = speedLow;
    flagsRaw[IDX_FAST]  = speedHigh;
    flagsRaw[IDX_EXT]   = extGate;
  end

  lfc_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .flagsRaw    (flagsRaw),
    .ctl         (ctl),
    .lampDemand  (lampDemand),
    .lampOn      (lampOn),
    .senseWindow (senseWindow)
  );

  lfc_control #(.BLANK_CYCLES(BLANK_CYCLES)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .pollTick   (pollTick),
    .lampDemand (lampDemand),
    .ctl        (ctl)
  );
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker (
  input logic clk,
  input logic rstN,
  input logic loadDump,
  input logic extGate,
  input logic pollTick,
  input logic lampOn,
  input logic senseWindow,
  input logic lampDemand,
  input logic blankActive
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  always_comb begin
    if (!rstN) AST_RESET_DARK: assert (!lampOn && !senseWindow); // R1
  end

  AST_DUMP_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(loadDump, 2)) |-> !lampOn); // R7

  AST_EXT_LIT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && $past(extGate, 2) && !$past(loadDump, 2))
      |-> (lampOn || blankActive)); // R6

  AST_POLL_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (pollTick && lampDemand && !blankActive) |=> (!lampOn && blankActive)); // R8

  AST_SENSE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    senseWindow |-> (!lampOn && blankActive)); // R9

  AST_SENSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    senseWindow |=> !senseWindow); // R9
endmodule

bind lamp_fault_ctrl lfc_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .loadDump    (loadDump),
  .extGate     (extGate),
  .pollTick    (pollTick),
  .lampOn      (lampOn),
  .senseWindow (senseWindow),
  .lampDemand  (lampDemand),
  .blankActive (ctl.blankActive)
);

// File: tb/lamp_fault_ctrl_test.sv
`timescale 1ns/1ps
module lamp_fault_ctrl_test;
  localparam int BLANK = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic underVolt = 0, overVolt = 0, loadDump = 0;
  logic speedLow = 0, speedHigh = 0, extGate = 0, pollTick = 0;
  logic lampOn, senseWindow;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state: two-deep delay line per flag, blank countdown
  int s1 [6];
  int s2 [6];
  int mCnt = 0;

  always #4 clk = ~clk;

  lamp_fault_ctrl #(.BLANK_CYCLES(BLANK)) uut (
    .clk(clk), .rstN(rstN), .underVolt(underVolt), .overVolt(overVolt),
    .loadDump(loadDump), .speedLow(speedLow), .speedHigh(speedHigh),
    .extGate(extGate), .pollTick(pollTick), .lampOn(lampOn),
    .senseWindow(senseWindow)
  );

  // order in arrays: under, over, dump, slow, fast, ext
  function automatic int demandOf();
    if (s2[2] != 0) return 0;
    if (s2[5] != 0) return 1;
    if (s2[1] != 0 || s2[3] != 0 || (s2[0] != 0 && s2[4] != 0)) return 1;
    return 0;
  endfunction

  task automatic step(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      int expLamp;
      int expSense;
      int cur [6];
      cur[0] = int'(underVolt); cur[1] = int'(overVolt); cur[2] = int'(loadDump);
      cur[3] = int'(speedLow);  cur[4] = int'(speedHigh); cur[5] = int'(extGate);
      if (rstN) begin
        if (mCnt != 0) mCnt = mCnt - 1;
        else if (pollTick && demandOf() == 1) mCnt = BLANK;
        for (int i = 0; i < 6; i++) begin
          s2[i] = s1[i];
          s1[i] = cur[i];
        end
      end
      @(posedge clk);
      #1;
      if (!rstN) begin
        mCnt = 0;
        for (int i = 0; i < 6; i++) begin s1[i] = 0; s2[i] = 0; end
      end
      expLamp  = (demandOf() == 1 && mCnt == 0) ? 1 : 0;
      expSense = (mCnt == 1) ? 1 : 0;
      vectors++;
      if (int'(lampOn) != expLamp || int'(senseWindow) != expSense) begin
        fails++;
        $display("FAIL %s: lampOn=%0d senseWindow=%0d expected lampOn=%0d senseWindow=%0d",
                 tag, lampOn, senseWindow, expLamp, expSense);
      end
    end
  endtask

  task automatic clearAll();
    underVolt = 0; overVolt = 0; loadDump = 0; speedLow = 0;
    speedHigh = 0; extGate = 0; pollTick = 0;
  endtask

  task automatic pollPulse(input string tag);
    pollTick = 1;
    step(1, tag);
    pollTick = 0;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin s1[i] = 0; s2[i] = 0; end
    #1;
    // R1: reset holds outputs low even with a fault present
    overVolt = 1; extGate = 1;
    step(4, "R1");
    clearAll();
    rstN = 1;
    step(3, "R5");

    // R11: two-edge latency, then R2 in every speed band
    overVolt = 1;
    step(3, "R11");
    speedHigh = 1; step(3, "R2");
    speedHigh = 0; speedLow = 1; step(3, "R2");
    clearAll(); step(4, "R5");

    // R3: undervoltage qualified by high speed
    underVolt = 1; step(4, "R3");
    speedHigh = 1; step(4, "R3");
    speedHigh = 0; step(4, "R3");
    clearAll(); step(3, "R5");

    // R4: slow rotor
    speedLow = 1; step(4, "R4");
    clearAll(); step(3, "R4");

    // R6: override alone
    extGate = 1; step(4, "R6");

    // R7: load dump beats override and faults
    loadDump = 1; overVolt = 1; speedLow = 1; step(5, "R7");
    loadDump = 0; step(4, "R7");
    clearAll(); step(3, "R5");

    // R8 / R9: blank while lit by override
    extGate = 1; step(3, "R8");
    pollPulse("R8");
    step(BLANK + 3, "R9");

    // R10: second tick inside a running blank
    pollPulse("R8");
    step(2, "R10");
    pollPulse("R10");
    step(BLANK + 2, "R10");

    // R10: tick with lamp not demanded
    clearAll(); step(3, "R10");
    pollPulse("R10");
    step(BLANK + 2, "R10");

    // R8 with fault source, demand dropped mid-blank
    overVolt = 1; step(3, "R8");
    pollPulse("R8");
    step(1, "R9");
    overVolt = 0; step(BLANK + 3, "R9");

    // R7 during a blank
    speedLow = 1; step(3, "R8");
    pollPulse("R8");
    loadDump = 1; step(BLANK + 3, "R7");
    clearAll(); step(3, "R5");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: lampOn=%0d expected run to complete", lampOn);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule